// File: doc/BRIEF.md
# Dual-Thread Level Interrupt Controller

This block collects 40 level-sensitive interrupt lines and presents them to two hardware threads, each through its own request output. Software enables or disables each source through two enable words and can observe the enabled, asserted sources through two pending words. The enable and pending words sit on a small word-wide register port. Nothing has to be written to clear an interrupt. A request follows its input level and falls once the device drops the line.

Sources not in a pair go to a single thread, chosen per source by an elaboration parameter; the default thread is CPU0. To let one source reach both threads, the integrator pairs a target number with a second, otherwise unused source number, its shadow. The target's own enable bit gates the CPU0 copy. The shadow's enable bit gates the CPU1 copy. The shadow number is never delivered on its own, so its input line is ignored. The pair table is a parameter of up to eight entries and is fixed at integration.

Top module: `dual_thread_intc`

## Requirements
- R1: While reset is asserted, and until the first write after it, every enable bit is 0, both request outputs are 0 and the read data output is 0.
- R2: The enable word at byte offset 0x04 holds sources 0 to 31, bit n for source n. A 1 enables the source and a 0 disables it. A write replaces the whole word, and a read returns the stored value.
- R3: The enable word at offset 0x50 holds sources 32 to 39 in bits 0 to 7, bit n-32 for source n. Bits 31:8 of this word read as 0, and writes to them have no effect.
- R4: Pending word 0x08 covers sources 0 to 31 and pending word 0x54 covers sources 32 to 39, with the same bit layout as the enable words. For an unpaired source, a bit is the input level ANDed with its own enable bit. For a target, it is the level ANDed with the OR of the target's and the shadow's enable bits. For a shadow number it is 0. Writes to pending words have no effect.
- R5: A read of any other offset, including an offset whose low two bits are not zero, returns 0. A write to such an offset changes no state.
- R6: Read data appears on the cycle after the read access and then holds its value until the next read.
- R7: An enabled, asserted unpaired source raises the request of exactly one thread. That thread is CPU1 if the source's routing parameter bit is set, and CPU0 otherwise.
- R8: For a pair (target T, shadow S), input T raises the CPU0 request when enable bit T is set, and raises the CPU1 request when enable bit S is set.
- R9: The input line of a shadow number never raises any request, whatever the enable bits hold.
- R10: Each request output is registered. It reflects the inputs and enable bits of the previous cycle, and it falls one cycle after its sources drop, with no register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_src | input | NUM_SRC | Level interrupt inputs, one per source number |
| bus_vld | input | 1 | Register access valid for one cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte address of the register word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| irq_cpu0 | output | 1 | Interrupt request to thread CPU0 |
| irq_cpu1 | output | 1 | Interrupt request to thread CPU1 |

## Verification
The hardest case to reach from the ports is a per-CPU pair split across the two enable words. In that case the target's enable bit and the shadow's enable bit sit in different registers, while the shadow's input line is also toggling. Random stimulus seldom isolates one such pair. Directed sequences therefore clear all enables, raise one target, and enable only its shadow (and then only the target) in both same-word and cross-word pairs, and they also drive a shadow line alone. Random phases then mix dense and sparse input and enable patterns so that pairs, routed sources and shadows interact.

// File: rtl/dtic_pkg.sv
package dtic_pkg;

  localparam int unsigned WORD_W   = 32;
  localparam int unsigned PAIR_MAX = 8;
  localparam int unsigned PAIR_EW  = 8;
  localparam int unsigned TABLE_W  = PAIR_MAX * PAIR_EW;

  localparam logic [31:0] OFS_EN_LO   = 32'h04;
  localparam logic [31:0] OFS_PEND_LO = 32'h08;
  localparam logic [31:0] OFS_EN_HI   = 32'h50;
  localparam logic [31:0] OFS_PEND_HI = 32'h54;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_EN_LO,
    SEL_EN_HI,
    SEL_PEND_LO,
    SEL_PEND_HI
  } reg_sel_e;

  function automatic reg_sel_e fn_decode(input logic [31:0] addr);
    reg_sel_e s;
    case (addr)
      OFS_EN_LO:   s = SEL_EN_LO;
      OFS_EN_HI:   s = SEL_EN_HI;
      OFS_PEND_LO: s = SEL_PEND_LO;
      OFS_PEND_HI: s = SEL_PEND_HI;
      default:     s = SEL_NONE;
    endcase
    return s;
  endfunction

  // Bit set of the source numbers listed in the first np entries of a table
  function automatic logic [63:0] fn_entry_set(input int unsigned np,
                                               input logic [TABLE_W-1:0] tbl);
    logic [63:0]        s;
    logic [PAIR_EW-1:0] e;
    s = '0;
    for (int k = 0; k < PAIR_MAX; k++) begin
      e = tbl[k*PAIR_EW +: PAIR_EW];
      if (k < int'(np)) s[e[5:0]] = 1'b1;
    end
    return s;
  endfunction

  // Shadow number paired with target idx (0 if idx is not a target)
  function automatic int unsigned fn_partner(input int unsigned np,
                                             input logic [TABLE_W-1:0] tgt,
                                             input logic [TABLE_W-1:0] shd,
                                             input int unsigned idx);
    int unsigned p;
    logic [PAIR_EW-1:0] t;
    logic [PAIR_EW-1:0] s;
    p = 0;
    for (int k = 0; k < PAIR_MAX; k++) begin
      t = tgt[k*PAIR_EW +: PAIR_EW];
      s = shd[k*PAIR_EW +: PAIR_EW];
      if (k < int'(np) && int'(t) == int'(idx)) p = int'(s[5:0]);
    end
    return p;
  endfunction

endpackage

// File: rtl/dtic_regs.sv
module dtic_regs
  import dtic_pkg::*;
#(
  parameter int unsigned NUM_SRC = 40
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  reg_sel_e           sel,
  input  logic [WORD_W-1:0]  wdata,
  output logic [NUM_SRC-1:0] en_vec
);

  localparam int unsigned HI_W = NUM_SRC - WORD_W;

  logic              lo_we;
  logic              hi_we;
  logic [WORD_W-1:0] lo_d;
  logic [WORD_W-1:0] lo_q;
  logic [HI_W-1:0]   hi_d;
  logic [HI_W-1:0]   hi_q;

  always_comb begin
    lo_we = wr_en && (sel == SEL_EN_LO);
    hi_we = wr_en && (sel == SEL_EN_HI);
    lo_d  = wdata;
    hi_d  = wdata[HI_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
    end else if (lo_we) begin
      lo_q <= lo_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
    end else if (hi_we) begin
      hi_q <= hi_d;
    end
  end

  assign en_vec = {hi_q, lo_q};

endmodule

// File: rtl/dtic_route.sv
module dtic_route
  import dtic_pkg::*;
#(
  parameter int unsigned          NUM_SRC    = 40,
  parameter int unsigned          NUM_PAIRS  = 1,
  parameter logic [TABLE_W-1:0]   PAIR_TGT   = 64'd30,
  parameter logic [TABLE_W-1:0]   PAIR_SHD   = 64'd29,
  parameter logic [NUM_SRC-1:0]   ROUTE_CPU1 = '0
) (
  input  logic [NUM_SRC-1:0] src,
  input  logic [NUM_SRC-1:0] en_vec,
  output logic [NUM_SRC-1:0] pend,
  output logic [NUM_SRC-1:0] to_c0,
  output logic [NUM_SRC-1:0] to_c1
);

  localparam logic [63:0] SHD_SET = fn_entry_set(NUM_PAIRS, PAIR_SHD);
  localparam logic [63:0] TGT_SET = fn_entry_set(NUM_PAIRS, PAIR_TGT);

  // Shadow input lines are intentionally left without a consumer
  logic [NUM_SRC-1:0] src_unused;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    if (SHD_SET[i]) begin : g_shadow
      assign pend[i]       = 1'b0;
      assign to_c0[i]      = 1'b0;
      assign to_c1[i]      = 1'b0;
      assign src_unused[i] = src[i];
    end else if (TGT_SET[i]) begin : g_target
      localparam int unsigned PARTNER = fn_partner(NUM_PAIRS, PAIR_TGT, PAIR_SHD, i);
      assign to_c0[i]      = src[i] & en_vec[i];
      assign to_c1[i]      = src[i] & en_vec[PARTNER];
      assign pend[i]       = src[i] & (en_vec[i] | en_vec[PARTNER]);
      assign src_unused[i] = 1'b0;
    end else if (ROUTE_CPU1[i]) begin : g_cpu1
      assign pend[i]       = src[i] & en_vec[i];
      assign to_c0[i]      = 1'b0;
      assign to_c1[i]      = src[i] & en_vec[i];
      assign src_unused[i] = 1'b0;
    end else begin : g_cpu0
      assign pend[i]       = src[i] & en_vec[i];
      assign to_c0[i]      = src[i] & en_vec[i];
      assign to_c1[i]      = 1'b0;
      assign src_unused[i] = 1'b0;
    end
  end

endmodule

// File: rtl/dtic_rdback.sv
module dtic_rdback
  import dtic_pkg::*;
#(
  parameter int unsigned NUM_SRC = 40
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_en,
  input  reg_sel_e           sel,
  input  logic [NUM_SRC-1:0] en_vec,
  input  logic [NUM_SRC-1:0] pend,
  output logic [WORD_W-1:0]  rdata
);

  localparam int unsigned HI_W = NUM_SRC - WORD_W;

  logic [WORD_W-1:0] rd_d;
  logic [WORD_W-1:0] rd_q;

  always_comb begin
    case (sel)
      SEL_EN_LO:   rd_d = en_vec[WORD_W-1:0];
      SEL_EN_HI:   rd_d = {{(WORD_W-HI_W){1'b0}}, en_vec[NUM_SRC-1:WORD_W]};
      SEL_PEND_LO: rd_d = pend[WORD_W-1:0];
      SEL_PEND_HI: rd_d = {{(WORD_W-HI_W){1'b0}}, pend[NUM_SRC-1:WORD_W]};
      default:     rd_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else if (rd_en) begin
      rd_q <= rd_d;
    end
  end

  assign rdata = rd_q;

endmodule

// File: rtl/dtic_irqout.sv
module dtic_irqout #(
  parameter int unsigned NUM_SRC = 40
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] to_c0,
  input  logic [NUM_SRC-1:0] to_c1,
  output logic               irq0,
  output logic               irq1
);

  logic irq0_d;
  logic irq1_d;
  logic irq0_q;
  logic irq1_q;

  always_comb begin
    irq0_d = |to_c0;
    irq1_d = |to_c1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq0_q <= 1'b0;
      irq1_q <= 1'b0;
    end else begin
      irq0_q <= irq0_d;
      irq1_q <= irq1_d;
    end
  end

  assign irq0 = irq0_q;
  assign irq1 = irq1_q;

endmodule

// File: rtl/dual_thread_intc.sv
module dual_thread_intc
  import dtic_pkg::*;
#(
  parameter int unsigned        NUM_SRC    = 40,
  parameter int unsigned        ADDR_W     = 8,
  parameter int unsigned        NUM_PAIRS  = 1,
  parameter logic [TABLE_W-1:0] PAIR_TGT   = 64'd30,
  parameter logic [TABLE_W-1:0] PAIR_SHD   = 64'd29,
  parameter logic [NUM_SRC-1:0] ROUTE_CPU1 = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_src,
  input  logic               bus_vld,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [WORD_W-1:0]  bus_wdata,
  output logic [WORD_W-1:0]  bus_rdata,
  output logic               irq_cpu0,
  output logic               irq_cpu1
);

  logic [1:0]         rst_pipe;
  logic               rst_sync_n;
  reg_sel_e           sel;
  logic               wr_en;
  logic               rd_en;
  logic [NUM_SRC-1:0] en_vec;
  logic [NUM_SRC-1:0] pend;
  logic [NUM_SRC-1:0] to_c0;
  logic [NUM_SRC-1:0] to_c1;

  // Reset: asserted asynchronously, released after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[1];

  always_comb begin
    sel   = fn_decode(32'(bus_addr));
    wr_en = bus_vld && bus_wr;
    rd_en = bus_vld && !bus_wr;
  end

  dtic_regs #(.NUM_SRC(NUM_SRC)) u_regs (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wr_en  (wr_en),
    .sel    (sel),
    .wdata  (bus_wdata),
    .en_vec (en_vec)
  );

  dtic_route #(
    .NUM_SRC    (NUM_SRC),
    .NUM_PAIRS  (NUM_PAIRS),
    .PAIR_TGT   (PAIR_TGT),
    .PAIR_SHD   (PAIR_SHD),
    .ROUTE_CPU1 (ROUTE_CPU1)
  ) u_route (
    .src    (irq_src),
    .en_vec (en_vec),
    .pend   (pend),
    .to_c0  (to_c0),
    .to_c1  (to_c1)
  );

  dtic_rdback #(.NUM_SRC(NUM_SRC)) u_rdback (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .rd_en  (rd_en),
    .sel    (sel),
    .en_vec (en_vec),
    .pend   (pend),
    .rdata  (bus_rdata)
  );

  dtic_irqout #(.NUM_SRC(NUM_SRC)) u_irqout (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .to_c0 (to_c0),
    .to_c1 (to_c1),
    .irq0  (irq_cpu0),
    .irq1  (irq_cpu1)
  );

endmodule

// File: rtl/dtic_chk.sv
module dtic_chk
  import dtic_pkg::*;
#(
  parameter int unsigned        NUM_SRC   = 40,
  parameter int unsigned        ADDR_W    = 8,
  parameter int unsigned        NUM_PAIRS = 1,
  parameter logic [TABLE_W-1:0] PAIR_TGT  = 64'd30,
  parameter logic [TABLE_W-1:0] PAIR_SHD  = 64'd29
) (
  input logic               clk,
  input logic               rst_sync_n,
  input logic               bus_vld,
  input logic               bus_wr,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [WORD_W-1:0]  bus_wdata,
  input logic [WORD_W-1:0]  bus_rdata,
  input logic               irq_cpu0,
  input logic               irq_cpu1,
  input logic [NUM_SRC-1:0] en_vec,
  input logic [NUM_SRC-1:0] to_c0,
  input logic [NUM_SRC-1:0] to_c1
);

  localparam int unsigned HI_W    = NUM_SRC - WORD_W;
  localparam logic [63:0] SHD_SET = fn_entry_set(NUM_PAIRS, PAIR_SHD);
  localparam logic [63:0] TGT_SET = fn_entry_set(NUM_PAIRS, PAIR_TGT);

  reg_sel_e chk_sel;
  logic     chk_rd;
  logic     chk_wr;
  always_comb begin
    chk_sel = fn_decode(32'(bus_addr));
    chk_rd  = bus_vld && !bus_wr;
    chk_wr  = bus_vld && bus_wr;
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_sync_n |=> (!irq_cpu0 && !irq_cpu1 && en_vec == '0 && bus_rdata == '0));

  assert_lo_write_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (chk_wr && chk_sel == SEL_EN_LO) |=> (en_vec[WORD_W-1:0] == $past(bus_wdata)));

  assert_hi_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (chk_rd && chk_sel == SEL_EN_HI) |=> (bus_rdata[WORD_W-1:HI_W] == '0));

  assert_unmapped_zero_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (chk_rd && chk_sel == SEL_NONE) |=> (bus_rdata == '0));

  assert_rdata_hold_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !chk_rd |=> $stable(bus_rdata));

  assert_single_thread_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((to_c0 & to_c1 & ~TGT_SET[NUM_SRC-1:0]) == '0));

  assert_shadow_silent_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (((to_c0 | to_c1) & SHD_SET[NUM_SRC-1:0]) == '0));

  assert_cpu0_latency_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq_cpu0 == $past(|to_c0));

  assert_cpu1_latency_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq_cpu1 == $past(|to_c1));

endmodule

bind dual_thread_intc dtic_chk #(
  .NUM_SRC   (NUM_SRC),
  .ADDR_W    (ADDR_W),
  .NUM_PAIRS (NUM_PAIRS),
  .PAIR_TGT  (PAIR_TGT),
  .PAIR_SHD  (PAIR_SHD)
) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .bus_vld    (bus_vld),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .irq_cpu0   (irq_cpu0),
  .irq_cpu1   (irq_cpu1),
  .en_vec     (en_vec),
  .to_c0      (to_c0),
  .to_c1      (to_c1)
);

// File: tb/dual_thread_intc_tb.sv
`timescale 1ns/1ps
module dual_thread_intc_tb;

  localparam int unsigned NSRC = 40;
  // Pairs (target, shadow): (30,29) same word, (39,33) high word, (5,36) cross word
  localparam logic [63:0]     TB_TGT   = 64'h0000_0000_0005_271E;
  localparam logic [63:0]     TB_SHD   = 64'h0000_0000_0024_211D;
  localparam logic [NSRC-1:0] TB_ROUTE = 40'h04_0000_3080; // 7,12,13,34 -> CPU1

  logic            clk;
  logic            rst_n;
  logic [NSRC-1:0] irq_src;
  logic            bus_vld;
  logic            bus_wr;
  logic [7:0]      bus_addr;
  logic [31:0]     bus_wdata;
  logic [31:0]     bus_rdata;
  logic            irq_cpu0;
  logic            irq_cpu1;

  int n_cmp;
  int n_bad;
  logic [NSRC-1:0] m_en;

  dual_thread_intc #(
    .NUM_SRC(NSRC), .ADDR_W(8), .NUM_PAIRS(3),
    .PAIR_TGT(TB_TGT), .PAIR_SHD(TB_SHD), .ROUTE_CPU1(TB_ROUTE)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .irq_src(irq_src),
    .bus_vld(bus_vld), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_cpu0(irq_cpu0), .irq_cpu1(irq_cpu1)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic bit is_shd(input int i);
    return (i == 29) || (i == 33) || (i == 36);
  endfunction

  function automatic int partner(input int i);
    if (i == 30) return 29;
    if (i == 39) return 33;
    if (i == 5)  return 36;
    return -1;
  endfunction

  function automatic logic [NSRC-1:0] m_pend(input logic [NSRC-1:0] s, input logic [NSRC-1:0] e);
    logic [NSRC-1:0] r;
    r = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (is_shd(i)) r[i] = 1'b0;
      else if (partner(i) >= 0) r[i] = s[i] & (e[i] | e[partner(i)]);
      else r[i] = s[i] & e[i];
    end
    return r;
  endfunction

  function automatic logic m_irq(input logic [NSRC-1:0] s, input logic [NSRC-1:0] e, input bit cpu1);
    logic r;
    r = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (is_shd(i)) r = r;
      else if (partner(i) >= 0) r = r | (s[i] & (cpu1 ? e[partner(i)] : e[i]));
      else if (TB_ROUTE[i] == cpu1) r = r | (s[i] & e[i]);
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_vld = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_vld = 1'b0; bus_wr = 1'b0;
    if (a == 8'h04) m_en[31:0] = d;
    if (a == 8'h50) m_en[39:32] = d[7:0];
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_vld = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_vld = 1'b0;
    d = bus_rdata;
  endtask

  task automatic chk_irq(input string req);
    chk(req, {62'd0, irq_cpu1, irq_cpu0},
        {62'd0, m_irq(irq_src, m_en, 1'b1), m_irq(irq_src, m_en, 1'b0)});
  endtask

  task automatic chk_pend(input string req);
    logic [31:0] d;
    logic [NSRC-1:0] p;
    p = m_pend(irq_src, m_en);
    rd(8'h08, d); chk(req, {32'd0, d}, {32'd0, p[31:0]});
    rd(8'h54, d); chk(req, {32'd0, d}, {56'd0, p[39:32]});
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired before the bench ended");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    logic [31:0] held;
    void'($urandom(32'd1234));
    n_cmp = 0; n_bad = 0; m_en = '0;
    rst_n = 1'b0; irq_src = '0; bus_vld = 1'b0; bus_wr = 1'b0;
    bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    chk("R1", {62'd0, irq_cpu1, irq_cpu0}, 64'd0);
    chk("R1", {32'd0, bus_rdata}, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: state after reset, all sources asserted but none enabled
    irq_src = '1;
    @(negedge clk);
    chk("R1", {62'd0, irq_cpu1, irq_cpu0}, 64'd0);
    rd(8'h04, d); chk("R1", {32'd0, d}, 64'd0);
    rd(8'h50, d); chk("R1", {32'd0, d}, 64'd0);
    irq_src = '0;

    // R2: low enable word read back
    wr(8'h04, 32'hA5C3_0F69);
    rd(8'h04, d); chk("R2", {32'd0, d}, 64'hA5C3_0F69);
    // R3: high word keeps only bits 7:0
    wr(8'h50, 32'hFFFF_FF5A);
    rd(8'h50, d); chk("R3", {32'd0, d}, 64'h5A);
    // R4: writes to pending words are ignored
    wr(8'h08, 32'h0000_0000);
    wr(8'h54, 32'h0000_0000);
    rd(8'h04, d); chk("R4", {32'd0, d}, 64'hA5C3_0F69);
    rd(8'h50, d); chk("R4", {32'd0, d}, 64'h5A);
    // R5: unmapped and unaligned accesses
    wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'h05, 32'hFFFF_FFFF);
    wr(8'h51, 32'hFFFF_FFFF);
    rd(8'h04, d); chk("R5", {32'd0, d}, 64'hA5C3_0F69);
    rd(8'h50, d); chk("R5", {32'd0, d}, 64'h5A);
    rd(8'h0C, d); chk("R5", {32'd0, d}, 64'd0);
    rd(8'h06, d); chk("R5", {32'd0, d}, 64'd0);
    rd(8'hFC, d); chk("R5", {32'd0, d}, 64'd0);
    // R6: read data holds across idle cycles and writes
    rd(8'h04, held);
    wr(8'h04, 32'h1111_2222);
    repeat (3) @(negedge clk);
    chk("R6", {32'd0, bus_rdata}, {32'd0, held});

    // R8: same-word pair 30/29
    wr(8'h04, 32'd0); wr(8'h50, 32'd0);
    irq_src = '0; irq_src[30] = 1'b1;
    wr(8'h04, 32'h4000_0000);
    @(negedge clk);
    chk("R8", {62'd0, irq_cpu1, irq_cpu0}, 64'b01);
    wr(8'h04, 32'h2000_0000);
    @(negedge clk);
    chk("R8", {62'd0, irq_cpu1, irq_cpu0}, 64'b10);
    chk_pend("R4");
    // R8: cross-word pair 5/36, shadow enable in high word
    wr(8'h04, 32'd0);
    irq_src = '0; irq_src[5] = 1'b1;
    wr(8'h50, 32'h10);
    @(negedge clk);
    chk("R8", {62'd0, irq_cpu1, irq_cpu0}, 64'b10);
    wr(8'h50, 32'h0); wr(8'h04, 32'h20);
    @(negedge clk);
    chk("R8", {62'd0, irq_cpu1, irq_cpu0}, 64'b01);
    // R9: shadow lines alone raise nothing
    irq_src = '0; irq_src[29] = 1'b1; irq_src[33] = 1'b1; irq_src[36] = 1'b1;
    wr(8'h04, 32'hFFFF_FFFF); wr(8'h50, 32'hFF);
    @(negedge clk);
    chk("R9", {62'd0, irq_cpu1, irq_cpu0}, 64'd0);
    chk_pend("R9");
    // R7: routed sources
    irq_src = '0; irq_src[12] = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R7", {62'd0, irq_cpu1, irq_cpu0}, 64'b10);
    irq_src = '0; irq_src[0] = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R7", {62'd0, irq_cpu1, irq_cpu0}, 64'b01);
    // R10: registered, clears without any write
    irq_src = '0;
    #1;
    chk("R10", {62'd0, irq_cpu1, irq_cpu0}, 64'b01);
    @(negedge clk);
    chk("R10", {62'd0, irq_cpu1, irq_cpu0}, 64'd0);

    // Random phase: dense and sparse patterns
    for (int it = 0; it < 300; it++) begin
      logic [31:0] lo;
      logic [31:0] hi;
      logic [63:0] s;
      lo = $urandom; hi = $urandom;
      s = {$urandom, $urandom};
      if (it[0]) begin lo = lo & $urandom & $urandom; s = s & {$urandom, $urandom}; end
      if (it[1]) s = s & {$urandom, $urandom} & {$urandom, $urandom};
      wr(8'h04, lo); wr(8'h50, hi);
      irq_src = s[NSRC-1:0];
      @(negedge clk);
      chk_irq("R7 R8 R9");
      chk_pend("R4");
      if (it % 8 == 0) begin
        rd(8'h04, d); chk("R2", {32'd0, d}, {32'd0, m_en[31:0]});
        rd(8'h50, d); chk("R3", {32'd0, d}, {56'd0, m_en[39:32]});
      end
    end
    finish_run();
  end

endmodule